// File: doc/BRIEF.md
# Fall-Through Marker FIFO

This block is an elastic queue that sits between a producer and a consumer that run at unrelated rates. It holds a chain of storage positions. Each position keeps one data word and a single flag bit that says whether the word is valid. A word enters at the input end of the chain. It then moves one position per clock toward the output end whenever the position ahead of it is vacant. Vacancies move toward the input end in the same way, so no read or write pointers are needed.

The producer offers a word by raising a push strobe. The consumer takes the word at the output by lowering a pop strobe. Both strobes are plain levels sampled on the system clock, and the block finds their edges itself. The input-ready flag is the inverse of the first position's valid bit. The output-ready flag is the last position's valid bit. Because of this, two copies can be chained in length with no glue logic. A flush input clears all valid bits, and an output-disable input freezes the output side.

Top module: `bubble_fifo`

## Requirements
- R1: After rst_n low or a one-cycle flush, out_ready is 0 and in_ready is 1 from the next cycle on. Flush leaves stored data unchanged, so out_data still shows the word that was last at the output.
- R2: A word on push_data is captured into the first position at the clock where push_strobe is high after being low (a rising edge) and in_ready is 1. A strobe held high stores exactly one word.
- R3: When a word is captured into an otherwise empty chain, in_ready is 0 for exactly one cycle and returns to 1 on the next clock.
- R4: Words advance one position per clock. A word captured into an empty chain at clock edge k makes out_ready 1 after edge k+DEPTH-1 and not before.
- R5: Once DEPTH words are stored, in_ready stays 0. A push pulse that rises and falls while the chain is full stores nothing.
- R6: A falling edge of pop_strobe while out_ready is 1 and out_disable is 0 removes the output word, and out_ready is 0 in the next cycle. Words leave in the order they were captured, and out_ready rises again when the next word arrives.
- R7: While the chain is empty, pop_strobe edges have no effect on any later word.
- R8: While out_disable is 1, no word is removed and out_data stays stable. out_valid equals the inverse of out_disable and marks when the data outputs would be driven.
- R9: If out_disable falls while pop_strobe is already low, the output word is removed at that clock.
- R10: Two instances can be chained by feeding the downstream push_strobe from the upstream out_ready, the downstream push_data from the upstream out_data, and the upstream pop_strobe from the downstream in_ready. The pair then stores 2*DEPTH words in order. A push strobe that rises while the chain is full and is still high when space opens is captured once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all valid bits; data is kept |
| push_strobe | input | 1 | Producer strobe; its rising edge offers push_data |
| push_data | input | WIDTH | Word to be stored |
| in_ready | output | 1 | First position is vacant |
| pop_strobe | input | 1 | Consumer strobe; its falling edge removes the output word |
| out_disable | input | 1 | Freezes removal; the data outputs count as undriven |
| out_ready | output | 1 | Last position holds a valid word |
| out_data | output | WIDTH | Word in the last position |
| out_valid | output | 1 | Data outputs would be driven (inverse of out_disable) |

## Verification
The count properties assume that only a push edge accepted while in_ready is high can add a word, and that only an enabled pop at the output can remove one. Both assumptions come from the port protocol. The stimulus raises each strobe for a single cycle and then holds it low for at least one cycle, except in the tests that deliberately hold push high or toggle out_disable while pop is low. The bench asserts flush only for single cycles while both strobes are low.

// File: rtl/bubble_fifo_pkg.sv
// Package: shared types for the fall-through marker FIFO.
// Assumes nothing beyond IEEE 1800-2017 enums.
package bubble_fifo_pkg;

    // Which transition of a sampled level counts as an event.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Samples a level every clock and flags the selected transition between the
// previous sample and the present level. Assumes the level is already
// synchronous to clk.
module strobe_edge #(
    parameter bubble_fifo_pkg::edge_kind_e KIND = bubble_fifo_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic hit
);

    logic prev_q;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    generate
        if (KIND == bubble_fifo_pkg::EDGE_RISE) begin : g_rise
            // Low-to-high transition.
            always_comb hit = level & ~prev_q;
        end else begin : g_fall
            // High-to-low transition.
            always_comb hit = ~level & prev_q;
        end
    endgenerate

endmodule

// File: rtl/bubble_cell.sv
// Module: bubble_cell
// One storage position of the chain. It takes the word offered from behind
// when it is vacant and the feed is valid. It drops its own valid bit when the
// position ahead signals that it takes the word. Decisions use only the
// registered valid bits of the previous cycle.
module bubble_cell #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             feed_mark,
    input  logic [WIDTH-1:0] feed_data,
    input  logic             leave,
    output logic             mark_q,
    output logic [WIDTH-1:0] data_q
);

    logic enter;

    // Accept a word only into a vacant slot, and never during a flush.
    always_comb enter = ~mark_q & feed_mark & ~flush;

    // Valid-bit update: clear on flush or departure, set on arrival.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)     mark_q <= 1'b0;
        else if (mark_q & leave) mark_q <= 1'b0;
        else if (enter)          mark_q <= 1'b1;
    end

    // Data latch: loads on arrival only, so reset and flush leave it intact.
    always_ff @(posedge clk) begin
        if (enter) data_q <= feed_data;
    end

endmodule

// File: rtl/bubble_fifo.sv
// Module: bubble_fifo (top)
// A chain of DEPTH positions with a valid bit each. A position with valid
// bit 0 whose predecessor has valid bit 1 pulls that word forward. The input
// flag is the first position's valid bit inverted, and the output flag is the
// last position's valid bit. Strobes are sampled as synchronous levels.
module bubble_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_strobe,
    input  logic [WIDTH-1:0] push_data,
    output logic             in_ready,
    input  logic             pop_strobe,
    input  logic             out_disable,
    output logic             out_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] mark;
    logic [DEPTH-1:0] feed_mark;
    logic [DEPTH-1:0] leave;
    logic [WIDTH-1:0] word      [DEPTH];
    logic [WIDTH-1:0] feed_word [DEPTH];

    logic push_rise, pop_fall, enable_fall;
    logic armed_q, push_pending, capture, remove;

    strobe_edge #(.KIND(bubble_fifo_pkg::EDGE_RISE)) u_push_edge (
        .clk(clk), .rst_n(rst_n), .level(push_strobe), .hit(push_rise)
    );

    strobe_edge #(.KIND(bubble_fifo_pkg::EDGE_FALL)) u_pop_edge (
        .clk(clk), .rst_n(rst_n), .level(pop_strobe), .hit(pop_fall)
    );

    strobe_edge #(.KIND(bubble_fifo_pkg::EDGE_FALL)) u_enable_edge (
        .clk(clk), .rst_n(rst_n), .level(out_disable), .hit(enable_fall)
    );

    // An offer stays pending while the strobe is high after a rising edge.
    always_comb push_pending = push_strobe & (push_rise | armed_q);
    // Capture the offer into the first position when it is vacant.
    always_comb capture = push_pending & ~mark[0] & ~flush;
    // Remove on a pop fall, or on re-enable while pop is already low.
    always_comb remove = mark[LAST] & ~out_disable & ~flush
                       & (pop_fall | (enable_fall & ~pop_strobe));

    // Keep a rising edge armed until it is used or the strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= push_pending & ~capture;
    end

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_pos
            if (i == 0) begin : g_head
                // The head is fed by the push port.
                always_comb feed_mark[i] = capture;
                always_comb feed_word[i] = push_data;
            end else begin : g_body
                // Other positions are fed by the position behind.
                always_comb feed_mark[i] = mark[i-1];
                always_comb feed_word[i] = word[i-1];
            end
            if (i == LAST) begin : g_tail
                // The tail empties only through the pop port.
                always_comb leave[i] = remove;
            end else begin : g_mid
                // A word departs when the position ahead is vacant.
                always_comb leave[i] = ~mark[i+1];
            end
            bubble_cell #(.WIDTH(WIDTH)) u_cell (
                .clk(clk), .rst_n(rst_n), .flush(flush),
                .feed_mark(feed_mark[i]), .feed_data(feed_word[i]),
                .leave(leave[i]), .mark_q(mark[i]), .data_q(word[i])
            );
        end
    endgenerate

    // Flags and the output word come straight from the end positions.
    always_comb begin
        in_ready  = ~mark[0];
        out_ready = mark[LAST];
        out_data  = word[LAST];
        out_valid = ~out_disable;
    end

endmodule

// File: rtl/bubble_fifo_chk.sv
// Module: bubble_fifo_chk
// Temporal checks on the FIFO, attached to every bubble_fifo by bind.
// Assumes that strobes are synchronous levels and that flush is synchronous.
module bubble_fifo_chk #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             push_strobe,
    input logic             pop_strobe,
    input logic             out_disable,
    input logic             in_ready,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_data,
    input logic [DEPTH-1:0] marks
);

    // R1: a flush leaves an empty chain with the input side open.
    assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_ready && in_ready));

    // R2: the word count grows only through an accepted push.
    assert_no_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_strobe && in_ready) |=> ($countones(marks) <= $past($countones(marks))));

    // R7: the word count shrinks only through an enabled pop (or flush).
    assert_no_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_strobe || out_disable || !out_ready) && !flush)
        |=> ($countones(marks) >= $past($countones(marks))));

    // R8: a held output word stays put while disabled or while pop is high.
    assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && (out_disable || pop_strobe) && !flush)
        |=> (out_ready && $stable(out_data)));

    // R6: a pop falling edge with outputs enabled empties the last position.
    assert_pop_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !out_disable && !flush && !pop_strobe
         && $past(pop_strobe) && $past(rst_n)) |=> !out_ready);

endmodule

bind bubble_fifo bubble_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_strobe(push_strobe),
    .pop_strobe(pop_strobe), .out_disable(out_disable), .in_ready(in_ready),
    .out_ready(out_ready), .out_data(out_data), .marks(mark)
);

// File: tb/test_bubble_fifo.sv
`timescale 1ns/1ps
module test_bubble_fifo;

    localparam int W = 4;
    localparam int D = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n, flush, push, pop, dis;
    logic [W-1:0] din;
    logic         in_ready, out_ready, out_valid;
    logic [W-1:0] dout;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bubble_fifo #(.WIDTH(W), .DEPTH(D)) i_bubble_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_strobe(push),
        .push_data(din), .in_ready(in_ready), .pop_strobe(pop),
        .out_disable(dis), .out_ready(out_ready), .out_data(dout),
        .out_valid(out_valid)
    );

    // Cascaded pair for R10.
    logic         c_push, c_pop;
    logic [W-1:0] c_din;
    logic         up_in_ready, up_out_ready, dn_in_ready, dn_out_ready;
    logic         up_valid, dn_valid;
    logic [W-1:0] up_dout, dn_dout;

    bubble_fifo #(.WIDTH(W), .DEPTH(D)) i_bubble_fifo_up (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push_strobe(c_push),
        .push_data(c_din), .in_ready(up_in_ready), .pop_strobe(dn_in_ready),
        .out_disable(1'b0), .out_ready(up_out_ready), .out_data(up_dout),
        .out_valid(up_valid)
    );

    bubble_fifo #(.WIDTH(W), .DEPTH(D)) i_bubble_fifo_down (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push_strobe(up_out_ready),
        .push_data(up_dout), .in_ready(dn_in_ready), .pop_strobe(c_pop),
        .out_disable(1'b0), .out_ready(dn_out_ready), .out_data(dn_dout),
        .out_valid(dn_valid)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] v);
        for (int t = 0; t < 200 && !in_ready; t++) @(negedge clk);
        din = v; push = 1'b1;
        @(negedge clk); push = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop_word(output bit ok, output logic [W-1:0] v);
        ok = 0; v = '0;
        for (int t = 0; t < 200; t++) begin
            if (out_ready) begin ok = 1; break; end
            @(negedge clk);
        end
        if (ok) begin
            v = dout; pop = 1'b1;
            @(negedge clk); pop = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic drain(input string req, ref logic [W-1:0] exp_q[$]);
        bit ok;
        logic [W-1:0] v;
        int n = 0;
        forever begin
            pop_word(ok, v);
            if (!ok) break;
            if (exp_q.size() == 0) check(req, int'(v), -1, "unexpected extra word");
            else check(req, int'(v), int'(exp_q.pop_front()), $sformatf("word %0d", n));
            n++;
        end
        check(req, exp_q.size(), 0, "words missing after drain");
    endtask

    task automatic do_flush();
        flush = 1'b1; @(negedge clk); flush = 1'b0;
    endtask

    initial begin
        logic [W-1:0] q[$];
        logic [W-1:0] val_a, val_b;
        rst_n = 0; flush = 0; push = 0; pop = 0; dis = 0; din = '0;
        c_push = 0; c_pop = 0; c_din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", in_ready, 1, "in_ready after reset");
        check("R1", out_ready, 0, "out_ready after reset");
        check("R8", out_valid, 1, "out_valid enabled");

        // R3 / R4: single word into an empty chain.
        val_a = 4'hA;
        din = val_a; push = 1'b1;
        @(negedge clk);
        check("R3", in_ready, 0, "in_ready one cycle after capture");
        push = 1'b0;
        @(negedge clk);
        check("R3", in_ready, 1, "in_ready two cycles after capture");
        repeat (D - 3) @(negedge clk);
        check("R4", out_ready, 0, "out_ready one cycle before arrival");
        @(negedge clk);
        check("R4", out_ready, 1, "out_ready at DEPTH-1 after capture");
        check("R4", dout, val_a, "arrived word");

        // R1: flush clears valid bits but keeps data.
        do_flush();
        check("R1", out_ready, 0, "out_ready after flush");
        check("R1", in_ready, 1, "in_ready after flush");
        check("R1", dout, val_a, "data kept through flush");

        // R8 / R9: output disable.
        val_b = 4'h5;
        push_word(val_b);
        repeat (D + 4) @(negedge clk);
        dis = 1'b1;
        @(negedge clk);
        check("R8", out_valid, 0, "out_valid while disabled");
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk); @(negedge clk);
        check("R8", out_ready, 1, "pop blocked while disabled");
        check("R8", dout, val_b, "word held while disabled");
        pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
        check("R8", out_ready, 1, "pop fall blocked while disabled");
        dis = 1'b0;
        @(negedge clk);
        check("R9", out_ready, 0, "re-enable with pop low removes word");
        check("R8", out_valid, 1, "out_valid after enable");

        // R7: pops on an empty chain are ignored.
        repeat (3) begin pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk); end
        check("R7", out_ready, 0, "out_ready stays low when empty");
        push_word(4'h3);
        q = {4'h3};
        drain("R7", q);

        // R2: push held high stores one word.
        din = 4'h9; push = 1'b1;
        repeat (10) @(negedge clk);
        din = 4'h6;
        repeat (30) @(negedge clk);
        push = 1'b0;
        @(negedge clk);
        q = {4'h9};
        drain("R2", q);

        // R5 / R6: fill completely, push while full, drain in order.
        do_flush();
        q = {};
        for (int i = 0; i < D; i++) begin
            push_word(W'(i * 7 + 1));
            q.push_back(W'(i * 7 + 1));
        end
        repeat (80) @(negedge clk);
        check("R5", in_ready, 0, "in_ready when full");
        din = 4'hF; push = 1'b1; @(negedge clk); push = 1'b0;
        repeat (80) @(negedge clk);
        check("R5", in_ready, 0, "in_ready still low after ignored push");
        drain("R5", q);

        // R6: sweep every fill level with its own data pattern.
        for (int k = 1; k <= D; k++) begin
            q = {};
            for (int i = 0; i < k; i++) begin
                push_word(W'(i * 5 + k));
                q.push_back(W'(i * 5 + k));
            end
            drain("R6", q);
            check("R6", out_ready, 0, $sformatf("empty after sweep %0d", k));
        end

        // R10: cascaded pair holds 2*DEPTH words in order.
        begin
            int stored = 0;
            bit stuck = 0;
            q = {};
            while (!stuck) begin
                int t = 0;
                while (!up_in_ready && t < 200) begin @(negedge clk); t++; end
                if (!up_in_ready) stuck = 1;
                else begin
                    c_din = W'(stored * 3 + 2); c_push = 1'b1;
                    @(negedge clk); c_push = 1'b0; @(negedge clk);
                    q.push_back(W'(stored * 3 + 2));
                    stored++;
                end
            end
            check("R10", stored, 2 * D, "cascade capacity");
            for (int n = 0; n < 2 * D + 2; n++) begin
                int t = 0;
                while (!dn_out_ready && t < 200) begin @(negedge clk); t++; end
                if (!dn_out_ready) break;
                if (q.size() == 0) check("R10", int'(dn_dout), -1, "extra cascade word");
                else check("R10", int'(dn_dout), int'(q.pop_front()), $sformatf("cascade word %0d", n));
                c_pop = 1'b1; @(negedge clk); c_pop = 1'b0; @(negedge clk);
            end
            check("R10", q.size(), 0, "cascade words missing");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule